// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block generates register-file addresses for a small 8-bit controller. It holds one combined byte register. The two upper bits of that byte choose a general-purpose bank, and the six lower bits are a pointer used for indirect accesses. On every cycle the block takes either the 6-bit direct address from the instruction or the pointer, depending on the indirect request. It then forms a 7-bit physical address in which only the upper half of the 6-bit space (20h to 3Fh) is banked. Addresses 00h to 1Fh always land on the same physical location.

The same byte is an ordinary read/write register. A normal register write replaces all eight bits. A dedicated bank instruction replaces only the two bank bits. The register contents are visible on an output at all times. The register file, the ALU and instruction decode lie outside the block.

Top module: `bank_addr_unit`

## Requirements
- R1: While `rst_n` is low the register is cleared to 00h, so after reset `ptr_q` reads 00h and `bank_idx` is 0.
- R2: With `wr_en` high and `bank_set_en` low, all eight bits of `wr_data` appear on `ptr_q` after the next rising clock edge.
- R3: With `bank_set_en` high and `wr_en` low, bits 7:6 of the register take `bank_code` after the next rising edge, and bits 5:0 keep their value.
- R4: When `wr_en` and `bank_set_en` are both high in the same cycle, bits 7:6 come from `bank_code` and bits 5:0 come from `wr_data[5:0]`.
- R5: When neither write input is high, the register holds its value.
- R6: When the effective address is in 00h to 1Fh (bit 5 clear), `phys_addr` equals `{1'b0, address}` whatever the bank bits hold.
- R7: When the effective address is in 20h to 3Fh (bit 5 set), `phys_addr` equals `{bank_idx, address}`.
- R8: With `ind_sel` high, the effective address is `ptr_q[5:0]` and `dir_addr` is ignored. With `ind_sel` low, the effective address is `dir_addr`.
- R9: The bank code in bits 7:6 maps as follows: code 00 gives bank 0, and codes 01, 10 and 11 give bank 1. `bank_idx` shows the mapped bank.
- R10: `phys_addr` and `bank_idx` are combinational. They follow the current register contents and the current `dir_addr` and `ind_sel` in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe for the full byte |
| wr_data | input | 8 | Data for a register write |
| bank_set_en | input | 1 | Bank instruction strobe, affects bits 7:6 only |
| bank_code | input | 2 | Bank code loaded by the bank instruction |
| ind_sel | input | 1 | 1: address through the pointer, 0: direct address |
| dir_addr | input | 6 | Direct address field from the instruction |
| ptr_q | output | 8 | Current register contents (read value) |
| bank_idx | output | 1 | Bank in force after code mapping |
| phys_addr | output | 7 | Physical register-file address |

## Verification
The assertions assume that `ind_sel` and `dir_addr` are stable, known values for the whole cycle in which the address is used. They also assume that the write strobes are never X while reset is released. The bench changes every input only at the falling clock edge and drives each one to a defined level at all times. It holds reset low from time zero and applies a second reset partway through, so no property sees undefined register contents. The stimulus exercises both write strobes alone and together, every bank code, and both halves of the address space through the direct path and through the pointer.

// File: rtl/bank_au_pkg.sv
package bank_au_pkg;

   // Source of the effective register address
   typedef enum logic {
      SRC_DIRECT  = 1'b0,
      SRC_POINTER = 1'b1
   } addr_src_e;

   // Map a request level to the address source
   function automatic addr_src_e pick_src(input logic ind);
      return ind ? SRC_POINTER : SRC_DIRECT;
   endfunction

endpackage

// File: rtl/bau_ptr_reg.sv
module bau_ptr_reg #(
   parameter int ADDR_W = 6,
   parameter int CODE_W = 2,
   localparam int REG_W = ADDR_W + CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              bank_set_en,
   input  logic [CODE_W-1:0] bank_code,
   output logic [REG_W-1:0]  ptr_q
);

   logic [REG_W-1:0] nxt;

   // Pointer field: only a full register write changes it
   for (genvar i = 0; i < ADDR_W; i++) begin : g_ptr_bit
      always_comb begin
         nxt[i] = wr_en ? wr_data[i] : ptr_q[i];
      end
   end

   // Bank field: the bank instruction wins over a same-cycle write
   for (genvar j = 0; j < CODE_W; j++) begin : g_code_bit
      always_comb begin
         if (bank_set_en)
            nxt[ADDR_W+j] = bank_code[j];
         else if (wr_en)
            nxt[ADDR_W+j] = wr_data[ADDR_W+j];
         else
            nxt[ADDR_W+j] = ptr_q[ADDR_W+j];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else
         ptr_q <= nxt;
   end

endmodule

// File: rtl/bau_bank_decode.sv
module bau_bank_decode #(
   parameter int CODE_W    = 2,
   parameter int NUM_BANKS = 2,
   localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [IDX_W-1:0]  idx_o
);

   localparam logic [CODE_W:0] LAST_BANK = (CODE_W+1)'(NUM_BANKS - 1);

   if (NUM_BANKS == (1 << CODE_W)) begin : g_direct
      // Every code names a bank of its own
      assign idx_o = code_i[IDX_W-1:0];
   end else begin : g_saturate
      // Codes beyond the last bank fold onto the last bank
      always_comb begin
         if ({1'b0, code_i} > LAST_BANK)
            idx_o = LAST_BANK[IDX_W-1:0];
         else
            idx_o = code_i[IDX_W-1:0];
      end
   end

endmodule

// File: rtl/bau_addr_map.sv
module bau_addr_map
   import bank_au_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int IDX_W  = 1,
   localparam int PHYS_W = ADDR_W + IDX_W
) (
   input  addr_src_e         src_i,
   input  logic [ADDR_W-1:0] dir_addr_i,
   input  logic [ADDR_W-1:0] ptr_addr_i,
   input  logic [IDX_W-1:0]  bank_i,
   output logic [PHYS_W-1:0] phys_o
);

   logic [ADDR_W-1:0] eff;
   logic              in_banked_half;

   always_comb begin
      eff            = (src_i == SRC_POINTER) ? ptr_addr_i : dir_addr_i;
      in_banked_half = eff[ADDR_W-1];
      phys_o         = {(in_banked_half ? bank_i : {IDX_W{1'b0}}), eff};
   end

endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
   import bank_au_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int CODE_W    = 2,
   parameter int NUM_BANKS = 2,
   localparam int REG_W    = ADDR_W + CODE_W,
   localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int PHYS_W   = ADDR_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              bank_set_en,
   input  logic [CODE_W-1:0] bank_code,
   input  logic              ind_sel,
   input  logic [ADDR_W-1:0] dir_addr,
   output logic [REG_W-1:0]  ptr_q,
   output logic [IDX_W-1:0]  bank_idx,
   output logic [PHYS_W-1:0] phys_addr
);

   // Elaboration-time parameter checks
   if (ADDR_W < 2) begin : g_bad_addr
      $error("bank_addr_unit: ADDR_W must be at least 2");
   end
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("bank_addr_unit: NUM_BANKS must be at least 2");
   end
   if (NUM_BANKS > (1 << CODE_W)) begin : g_bad_code
      $error("bank_addr_unit: CODE_W too narrow for NUM_BANKS");
   end

   addr_src_e src;

   assign src = pick_src(ind_sel);

   bau_ptr_reg #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W)
   ) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .bank_set_en (bank_set_en),
      .bank_code   (bank_code),
      .ptr_q       (ptr_q)
   );

   bau_bank_decode #(
      .CODE_W    (CODE_W),
      .NUM_BANKS (NUM_BANKS)
   ) u_dec (
      .code_i (ptr_q[REG_W-1:ADDR_W]),
      .idx_o  (bank_idx)
   );

   bau_addr_map #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_map (
      .src_i      (src),
      .dir_addr_i (dir_addr),
      .ptr_addr_i (ptr_q[ADDR_W-1:0]),
      .bank_i     (bank_idx),
      .phys_o     (phys_addr)
   );

endmodule

// File: rtl/bau_checker.sv
module bau_checker #(
   parameter int ADDR_W    = 6,
   parameter int CODE_W    = 2,
   parameter int NUM_BANKS = 2,
   localparam int REG_W    = ADDR_W + CODE_W,
   localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int PHYS_W   = ADDR_W + IDX_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_W-1:0]  wr_data,
   input logic              bank_set_en,
   input logic [CODE_W-1:0] bank_code,
   input logic              ind_sel,
   input logic [ADDR_W-1:0] dir_addr,
   input logic [REG_W-1:0]  ptr_q,
   input logic [IDX_W-1:0]  bank_idx,
   input logic [PHYS_W-1:0] phys_addr
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (ptr_q == '0));

   // R2
   full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !bank_set_en) |=> (ptr_q == $past(wr_data)));

   // R3
   bank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_set_en && !wr_en) |=>
         (ptr_q[REG_W-1:ADDR_W] == $past(bank_code)) &&
         (ptr_q[ADDR_W-1:0] == $past(ptr_q[ADDR_W-1:0])));

   // R4
   merge_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_set_en && wr_en) |=>
         (ptr_q[REG_W-1:ADDR_W] == $past(bank_code)) &&
         (ptr_q[ADDR_W-1:0] == $past(wr_data[ADDR_W-1:0])));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !bank_set_en) |=> $stable(ptr_q));

   // R6
   low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ind_sel && !dir_addr[ADDR_W-1]) |->
         (phys_addr == {{IDX_W{1'b0}}, dir_addr}));

   // R7
   high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ind_sel && dir_addr[ADDR_W-1]) |->
         (phys_addr == {bank_idx, dir_addr}));

   // R8
   pointer_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ind_sel |-> (phys_addr[ADDR_W-1:0] == ptr_q[ADDR_W-1:0]));

   // R9
   bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q[REG_W-1:ADDR_W] == '0) |-> (bank_idx == '0));

   // R9
   bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q[REG_W-1:ADDR_W] != '0) |-> (bank_idx != '0));

endmodule

bind bank_addr_unit bau_checker #(
   .ADDR_W    (ADDR_W),
   .CODE_W    (CODE_W),
   .NUM_BANKS (NUM_BANKS)
) u_chk (.*);

// File: tb/bank_addr_unit_bench.sv
module bank_addr_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       bank_set_en = 1'b0;
   logic [1:0] bank_code = 2'b00;
   logic       ind_sel = 1'b0;
   logic [5:0] dir_addr = 6'h00;
   logic [7:0] ptr_q;
   logic [0:0] bank_idx;
   logic [6:0] phys_addr;

   always #2.5 clk = ~clk;  // 200 MHz

   bank_addr_unit u_bank_addr_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .bank_set_en (bank_set_en),
      .bank_code   (bank_code),
      .ind_sel     (ind_sel),
      .dir_addr    (dir_addr),
      .ptr_q       (ptr_q),
      .bank_idx    (bank_idx),
      .phys_addr   (phys_addr)
   );

   typedef struct {
      logic [7:0] ptr;
      logic       bank;
      logic [6:0] phys;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;
   logic [7:0] m_ptr = 8'h00;

   // Independent model of the bank mapping (R9)
   function automatic logic map_bank(input logic [1:0] code);
      return (code == 2'b00) ? 1'b0 : 1'b1;
   endfunction

   // Driver: apply one cycle of stimulus, push expected outputs, advance model
   task automatic step(input logic we, input logic [7:0] wd, input logic bs,
                       input logic [1:0] bc, input logic ind,
                       input logic [5:0] da, input string tag);
      exp_t       e;
      logic [5:0] eff;
      logic [7:0] nx;
      @(negedge clk);
      wr_en = we; wr_data = wd; bank_set_en = bs; bank_code = bc;
      ind_sel = ind; dir_addr = da;
      eff    = ind ? m_ptr[5:0] : da;
      e.ptr  = m_ptr;
      e.bank = map_bank(m_ptr[7:6]);
      e.phys = eff[5] ? {e.bank, eff} : {1'b0, eff};
      e.tag  = tag;
      sb.push_back(e);
      nx = m_ptr;
      if (we) nx = wd;
      if (bs) nx[7:6] = bc;
      m_ptr = nx;
   endtask

   task automatic do_reset();
      @(negedge clk);
      wr_en = 1'b0; bank_set_en = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      m_ptr = 8'h00;
      rst_n = 1'b1;
   endtask

   // Monitor: compare the oldest expected item mid-phase
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (ptr_q !== e.ptr || bank_idx[0] !== e.bank || phys_addr !== e.phys) begin
               n_bad++;
               $display("FAIL %s: ptr=%h bank=%b phys=%h expected ptr=%h bank=%b phys=%h",
                        e.tag, ptr_q, bank_idx, phys_addr, e.ptr, e.bank, e.phys);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step(0, 8'h00, 0, 2'b00, 0, 6'h00, "R1");
      // R6 low half with bank 0
      step(0, 8'h00, 0, 2'b00, 0, 6'h10, "R6");
      // R2 full write 40h (code 01)
      step(1, 8'h40, 0, 2'b00, 0, 6'h00, "R2");
      // R7 / R9 high half in bank 1
      step(0, 8'h00, 0, 2'b00, 0, 6'h25, "R7");
      // R6 low half ignores bank 1
      step(0, 8'h00, 0, 2'b00, 0, 6'h05, "R6");
      // R3 bank instruction to code 00 keeps pointer
      step(0, 8'hFF, 1, 2'b00, 0, 6'h3F, "R3");
      step(1, 8'h3A, 0, 2'b00, 0, 6'h3F, "R2");
      // R3 code 10 keeps pointer 3Ah
      step(0, 8'h00, 1, 2'b10, 0, 6'h3F, "R3");
      // R9 code 10 maps to bank 1
      step(0, 8'h00, 0, 2'b00, 0, 6'h3F, "R9");
      // R9 code 11 maps to bank 1
      step(1, 8'hC0, 0, 2'b00, 0, 6'h20, "R2");
      step(0, 8'h00, 0, 2'b00, 0, 6'h20, "R9");
      // R8 pointer path, banked and unbanked targets
      step(1, 8'h62, 0, 2'b00, 1, 6'h00, "R8");
      step(0, 8'h00, 0, 2'b00, 1, 6'h1F, "R8");
      step(1, 8'h45, 0, 2'b00, 1, 6'h3F, "R8");
      step(0, 8'h00, 0, 2'b00, 1, 6'h3F, "R8");
      // R4 simultaneous write and bank instruction
      step(1, 8'h07, 1, 2'b01, 0, 6'h00, "R4");
      step(1, 8'hBF, 1, 2'b00, 1, 6'h00, "R4");
      step(0, 8'h00, 0, 2'b00, 1, 6'h00, "R4");
      // R5 hold with data present but no strobe
      for (int k = 0; k < 4; k++)
         step(0, 8'hA5 + 8'(k), 0, 2'b11, 0, 6'h2A, "R5");
      // R10 sweep of direct addresses under bank 0 and bank 1
      step(1, 8'h00, 0, 2'b00, 0, 6'h00, "R10");
      for (int a = 0; a < 64; a++)
         step(0, 8'h00, 0, 2'b00, 0, 6'(a), "R10");
      step(0, 8'h00, 1, 2'b01, 0, 6'h00, "R10");
      for (int a = 0; a < 64; a++)
         step(0, 8'h00, 0, 2'b00, 0, 6'(a), "R10");
      // R1 reset partway through
      step(1, 8'hE9, 0, 2'b00, 0, 6'h00, "R2");
      do_reset();
      step(0, 8'h00, 0, 2'b00, 1, 6'h00, "R1");
      step(0, 8'h00, 0, 2'b00, 0, 6'h3C, "R1");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule